// File: doc/BRIEF.md
# Privilege-Ring Access Rights Checker

This block decides whether one memory access may go ahead once the translation lookup has run. It takes a virtual address, the requester's privilege ring (0 is the most privileged, 3 the least), a flag that marks untranslated (physical) mode, and the access kind. It also takes the fields of the matching translation entry, or an indication that no valid entry was found. From these it forms the physical address, a mask of the rights that remain (read, write, execute) and a 4-bit fault code. Only that code says whether the access is refused, and for what reason.

Rights come from two ring bounds stored in the entry and a 3-bit page type. When protection checking is on, an entry that carries a nonzero owner tag is compared against four protection-ID registers. The entry's status bits (dirty, break, reference-trap) are then applied in a fixed order, and each later fault replaces the earlier one. A non-architectural probe returns only the translation and mask. All results are registered and appear one cycle after a valid request.

Top module: `ring_access_checker`

## Requirements
- R1: With `req_phys_mode` set, `out_pa` equals the virtual address, `out_perm` is 3'b111 and `out_fault` is 0, whatever the entry holds.
- R2: Outside physical mode, with `ent_hit` low, `out_pa` and `out_perm` are 0. `out_fault` is 1 (instruction-TLB miss) for kind 3 (execute) and 2 (data-TLB miss) for any other kind.
- R3: On a hit, `out_pa` is `ent_frame` concatenated above the low `PAGE_BITS` bits of `req_va`.
- R4: Ring rights: read needs ring <= `ent_pl_rd`, write needs ring <= `ent_pl_wr`, and execute needs `ent_pl_wr` <= ring <= `ent_pl_rd`. The mask bits are bit0 read, bit1 write, bit2 execute.
- R5: Page types gate the ring rights: type 0 allows read, 1 allows read and write, 2 allows read and execute, 3 allows all three, and 4 to 7 allow execute only.
- R6: When `pid_check_en` is 1 and `ent_aid` is nonzero, the key {ent_aid, 1'b1}, zero-extended to `PID_W`, is compared with each of the four protection-ID registers. On a match, write is cleared from the mask, and a write access gets fault 3 (protection-ID) with no later check.
- R7: With `pid_check_en` at 0, or with `ent_aid` equal to 0, a protection-ID register that equals the key has no effect on the mask or the fault.
- R8: Kind 0 (probe) on a hit returns the address and the mask after steps R4 to R6 with fault 0. Status bits do not narrow its mask.
- R9: A read (kind 1), write (kind 2) or execute (kind 3) whose right is missing from the mask faults. Execute gives 4 (instruction protection). Otherwise the fault is 5 (data protection) if read is in the mask and 6 (data access rights) if it is not. No status check follows.
- R10: With the rights check passed, `ent_dirty` low clears write from the mask, and a write access faults with 7 (dirty).
- R11: With the rights check passed, `ent_brk` high clears write from the mask, and a write access faults with 8 (break). This replaces a dirty fault.
- R12: With the rights check passed, `ent_ref_trap` high leaves only execute in the mask, and a read or write access faults with 9 (page reference). This replaces a dirty or break fault.
- R13: `out_valid` follows `req_valid` one cycle later. Results change only in a cycle after a valid request. After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_va | input | VA_W | Virtual address |
| req_phys_mode | input | 1 | Untranslated access |
| req_ring | input | 2 | Requester privilege ring 0..3 |
| req_kind | input | 2 | 0 probe, 1 read, 2 write, 3 execute |
| ent_hit | input | 1 | Lookup found a valid entry |
| ent_frame | input | PA_W-PAGE_BITS | Physical frame number of the entry |
| ent_aid | input | AID_W | Owner tag of the entry, 0 for public |
| ent_pl_rd | input | 2 | Ring bound for read (upper execute bound) |
| ent_pl_wr | input | 2 | Ring bound for write (lower execute bound) |
| ent_type | input | 3 | Page type code |
| ent_brk | input | 1 | Break-on-write bit |
| ent_dirty | input | 1 | Page already written |
| ent_ref_trap | input | 1 | Trap on data reference |
| pid_regs | input | N_PID*PID_W | Protection-ID registers, register k at bits k*PID_W upward |
| pid_check_en | input | 1 | Protection-ID checking enabled |
| out_valid | output | 1 | Result valid |
| out_pa | output | PA_W | Physical address |
| out_perm | output | 3 | Remaining rights, bit0 R, bit1 W, bit2 X |
| out_fault | output | 4 | Fault code, 0 for none |

## Verification
The assertions take two things for granted. Every request field is a known value in any cycle where `req_valid` is high, and the protection-ID registers and enable bit stay steady while a request is sampled. Their implications are tied to `req_valid`, so values on idle cycles are never checked. The stimulus drives every field on the falling edge, before the sampling edge, from a fixed-seed generator. It mixes a fair share of physical-mode, miss and probe cases with random ring bounds and types. It sometimes loads a protection-ID register with the entry's own key, so the match path is reached often rather than by chance.

// File: rtl/rac_pkg.sv
package rac_pkg;

  localparam logic [1:0] KIND_PROBE = 2'd0;
  localparam logic [1:0] KIND_READ  = 2'd1;
  localparam logic [1:0] KIND_WRITE = 2'd2;
  localparam logic [1:0] KIND_EXEC  = 2'd3;

  localparam int PERM_R = 0;
  localparam int PERM_W = 1;
  localparam int PERM_X = 2;

  localparam logic [3:0] FLT_NONE      = 4'd0;
  localparam logic [3:0] FLT_ITLB_MISS = 4'd1;
  localparam logic [3:0] FLT_DTLB_MISS = 4'd2;
  localparam logic [3:0] FLT_PID       = 4'd3;
  localparam logic [3:0] FLT_IPROT     = 4'd4;
  localparam logic [3:0] FLT_DPROT     = 4'd5;
  localparam logic [3:0] FLT_DRIGHTS   = 4'd6;
  localparam logic [3:0] FLT_DIRTY     = 4'd7;
  localparam logic [3:0] FLT_BREAK     = 4'd8;
  localparam logic [3:0] FLT_PAGEREF   = 4'd9;

  // Rights earned from the ring bounds before the page type is applied.
  function automatic logic [2:0] ring_rights(input logic [1:0] ring,
                                             input logic [1:0] pl_rd,
                                             input logic [1:0] pl_wr);
    logic [2:0] m;
    m[PERM_R] = (ring <= pl_rd);
    m[PERM_W] = (ring <= pl_wr);
    m[PERM_X] = (pl_wr <= ring) && (ring <= pl_rd);
    return m;
  endfunction

  // Rights a page type may grant at most.
  function automatic logic [2:0] type_grant(input logic [2:0] typ);
    logic [2:0] g;
    case (typ)
      3'd0:    g = 3'b001;
      3'd1:    g = 3'b011;
      3'd2:    g = 3'b101;
      3'd3:    g = 3'b111;
      default: g = 3'b100;
    endcase
    return g;
  endfunction

  // Mask bit that a given access kind needs.
  function automatic logic [2:0] kind_need(input logic [1:0] kind);
    logic [2:0] n;
    case (kind)
      KIND_READ:  n = 3'b001;
      KIND_WRITE: n = 3'b010;
      KIND_EXEC:  n = 3'b100;
      default:    n = 3'b000;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/rac_rights.sv
module rac_rights
  import rac_pkg::*;
(
  input  logic [1:0] ring,
  input  logic [1:0] pl_rd,
  input  logic [1:0] pl_wr,
  input  logic [2:0] typ,
  output logic [2:0] base_perm
);
  logic [2:0] ring_mask;
  logic [2:0] grant_mask;

  always_comb begin
    ring_mask  = ring_rights(ring, pl_rd, pl_wr);
    grant_mask = type_grant(typ);
    // Read is never granted alone by the ring check once the type forbids it.
    base_perm  = ring_mask & grant_mask;
  end
endmodule

// File: rtl/rac_pid_match.sv
module rac_pid_match #(
  parameter int AID_W = 18,
  parameter int PID_W = 32,
  parameter int N_PID = 4
) (
  input  logic [AID_W-1:0]       aid,
  input  logic [N_PID*PID_W-1:0] pid_regs,
  input  logic                   check_en,
  output logic                   pid_hit
);
  localparam int PAD_W = PID_W - AID_W - 1;

  logic [PID_W-1:0] key;
  logic [N_PID-1:0] lane_eq;

  assign key = {{PAD_W{1'b0}}, aid, 1'b1};

  for (genvar k = 0; k < N_PID; k++) begin : g_lane
    assign lane_eq[k] = (pid_regs[k*PID_W +: PID_W] == key);
  end

  assign pid_hit = check_en && (aid != '0) && (|lane_eq);
endmodule

// File: rtl/rac_resolve.sv
module rac_resolve
  import rac_pkg::*;
(
  input  logic       phys_mode,
  input  logic       hit,
  input  logic [1:0] kind,
  input  logic [2:0] base_perm,
  input  logic       pid_hit,
  input  logic       brk,
  input  logic       dirty,
  input  logic       ref_trap,
  output logic [2:0] perm,
  output logic [3:0] fault,
  output logic       rights_fail
);
  logic [2:0] need;

  always_comb begin
    need        = kind_need(kind);
    perm        = base_perm;
    fault       = FLT_NONE;
    rights_fail = 1'b0;
    if (phys_mode) begin
      perm = 3'b111;
    end else if (!hit) begin
      perm  = 3'b000;
      fault = (kind == KIND_EXEC) ? FLT_ITLB_MISS : FLT_DTLB_MISS;
    end else begin
      if (pid_hit) begin
        perm[PERM_W] = 1'b0;
        if (kind == KIND_WRITE) fault = FLT_PID;
      end
      if (fault == FLT_NONE && kind != KIND_PROBE) begin
        if ((perm & need) == 3'b000) begin
          rights_fail = 1'b1;
          if (kind == KIND_EXEC)  fault = FLT_IPROT;
          else if (perm[PERM_R])  fault = FLT_DPROT;
          else                    fault = FLT_DRIGHTS;
        end else begin
          // Lowest priority first; each later hit overrides the code.
          if (!dirty) begin
            if (kind == KIND_WRITE) fault = FLT_DIRTY;
            perm[PERM_W] = 1'b0;
          end
          if (brk) begin
            if (kind == KIND_WRITE) fault = FLT_BREAK;
            perm[PERM_W] = 1'b0;
          end
          if (ref_trap) begin
            if (kind != KIND_EXEC) fault = FLT_PAGEREF;
            perm = perm & 3'b100;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ring_access_checker.sv
module ring_access_checker
  import rac_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int AID_W     = 18,
  parameter int PID_W     = 32,
  parameter int N_PID     = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [VA_W-1:0]           req_va,
  input  logic                      req_phys_mode,
  input  logic [1:0]                req_ring,
  input  logic [1:0]                req_kind,
  input  logic                      ent_hit,
  input  logic [PA_W-PAGE_BITS-1:0] ent_frame,
  input  logic [AID_W-1:0]          ent_aid,
  input  logic [1:0]                ent_pl_rd,
  input  logic [1:0]                ent_pl_wr,
  input  logic [2:0]                ent_type,
  input  logic                      ent_brk,
  input  logic                      ent_dirty,
  input  logic                      ent_ref_trap,
  input  logic [N_PID*PID_W-1:0]    pid_regs,
  input  logic                      pid_check_en,
  output logic                      out_valid,
  output logic [PA_W-1:0]           out_pa,
  output logic [2:0]                out_perm,
  output logic [3:0]                out_fault
);
  localparam int FRAME_W = PA_W - PAGE_BITS;

  logic [2:0]      base_perm;
  logic            pid_hit;
  logic [2:0]      perm_nxt;
  logic [3:0]      fault_nxt;
  logic            rights_fail;
  logic [PA_W-1:0] va_as_pa;
  logic [PA_W-1:0] xlat_pa;
  logic [PA_W-1:0] pa_nxt;

  rac_rights u_rights (
    .ring      (req_ring),
    .pl_rd     (ent_pl_rd),
    .pl_wr     (ent_pl_wr),
    .typ       (ent_type),
    .base_perm (base_perm)
  );

  rac_pid_match #(.AID_W(AID_W), .PID_W(PID_W), .N_PID(N_PID)) u_pid (
    .aid      (ent_aid),
    .pid_regs (pid_regs),
    .check_en (pid_check_en),
    .pid_hit  (pid_hit)
  );

  rac_resolve u_resolve (
    .phys_mode   (req_phys_mode),
    .hit         (ent_hit),
    .kind        (req_kind),
    .base_perm   (base_perm),
    .pid_hit     (pid_hit),
    .brk         (ent_brk),
    .dirty       (ent_dirty),
    .ref_trap    (ent_ref_trap),
    .perm        (perm_nxt),
    .fault       (fault_nxt),
    .rights_fail (rights_fail)
  );

  if (PA_W > VA_W) begin : g_widen
    assign va_as_pa = {{(PA_W-VA_W){1'b0}}, req_va};
  end else begin : g_narrow
    assign va_as_pa = req_va[PA_W-1:0];
  end

  assign xlat_pa = {ent_frame[FRAME_W-1:0], req_va[PAGE_BITS-1:0]};

  always_comb begin
    if (req_phys_mode) pa_nxt = va_as_pa;
    else if (!ent_hit) pa_nxt = '0;
    else               pa_nxt = xlat_pa;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pa    <= '0;
      out_perm  <= 3'b000;
      out_fault <= FLT_NONE;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_pa    <= pa_nxt;
        out_perm  <= perm_nxt;
        out_fault <= fault_nxt;
      end
    end
  end

  // R1
  phys_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_phys_mode |=> out_perm == 3'b111 && out_fault == FLT_NONE
                                   && out_pa == $past(va_as_pa));

  // R2
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_phys_mode && !ent_hit |=> out_perm == 3'b000
      && (out_fault == FLT_ITLB_MISS || out_fault == FLT_DTLB_MISS));

  // R6
  pid_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_phys_mode && ent_hit && pid_hit && req_kind == KIND_WRITE
      |=> out_fault == FLT_PID && !out_perm[PERM_W]);

  // R8
  probe_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_phys_mode && ent_hit && req_kind == KIND_PROBE
      |=> out_fault == FLT_NONE);

  // R9
  rights_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_phys_mode && ent_hit && rights_fail
      |=> out_fault == FLT_IPROT || out_fault == FLT_DPROT || out_fault == FLT_DRIGHTS);

  // R10
  no_write_on_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_fault == FLT_DIRTY || out_fault == FLT_BREAK) |-> !out_perm[PERM_W]);

  // R12
  pageref_exec_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fault == FLT_PAGEREF |-> out_perm[1:0] == 2'b00);

  // R13
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);

  // R13
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid && $stable(out_fault) && $stable(out_perm));

endmodule

// File: tb/tb_ring_access_checker.sv
`timescale 1ns/1ps
module tb_ring_access_checker;
  localparam int VA_W = 32, PA_W = 32, PAGE_BITS = 12, AID_W = 18, PID_W = 32, N_PID = 4;
  localparam int FR_W = PA_W - PAGE_BITS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [VA_W-1:0] req_va = '0;
  logic req_phys_mode = 1'b0;
  logic [1:0] req_ring = '0, req_kind = '0;
  logic ent_hit = 1'b0;
  logic [FR_W-1:0] ent_frame = '0;
  logic [AID_W-1:0] ent_aid = '0;
  logic [1:0] ent_pl_rd = '0, ent_pl_wr = '0;
  logic [2:0] ent_type = '0;
  logic ent_brk = 1'b0, ent_dirty = 1'b0, ent_ref_trap = 1'b0;
  logic [N_PID*PID_W-1:0] pid_regs = '0;
  logic pid_check_en = 1'b0;
  logic out_valid;
  logic [PA_W-1:0] out_pa;
  logic [2:0] out_perm;
  logic [3:0] out_fault;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ring_access_checker #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS),
                        .AID_W(AID_W), .PID_W(PID_W), .N_PID(N_PID)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .req_phys_mode(req_phys_mode), .req_ring(req_ring), .req_kind(req_kind),
    .ent_hit(ent_hit), .ent_frame(ent_frame), .ent_aid(ent_aid),
    .ent_pl_rd(ent_pl_rd), .ent_pl_wr(ent_pl_wr), .ent_type(ent_type),
    .ent_brk(ent_brk), .ent_dirty(ent_dirty), .ent_ref_trap(ent_ref_trap),
    .pid_regs(pid_regs), .pid_check_en(pid_check_en),
    .out_valid(out_valid), .out_pa(out_pa), .out_perm(out_perm), .out_fault(out_fault));

  task automatic check(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference: status bits resolved highest-priority first.
  task automatic model(output logic [PA_W-1:0] pa, output logic [2:0] perm,
                       output logic [3:0] flt, output string tag);
    bit r, w, x, matched, need_ok;
    logic [PID_W-1:0] key;
    pa = '0; perm = 3'b000; flt = 4'd0; tag = "R4";
    if (req_phys_mode) begin
      pa = req_va; perm = 3'b111; tag = "R1"; return;
    end
    if (!ent_hit) begin
      flt = (req_kind == 2'd3) ? 4'd1 : 4'd2; tag = "R2"; return;
    end
    pa = {ent_frame, req_va[PAGE_BITS-1:0]};
    r = (req_ring <= ent_pl_rd) && (ent_type < 3'd4);
    w = (req_ring <= ent_pl_wr) && (ent_type == 3'd1 || ent_type == 3'd3);
    x = (req_ring >= ent_pl_wr) && (req_ring <= ent_pl_rd) && (ent_type >= 3'd2);
    key = PID_W'({ent_aid, 1'b1});
    matched = 1'b0;
    for (int k = 0; k < N_PID; k++)
      if (pid_regs[k*PID_W +: PID_W] == key) matched = 1'b1;
    if (pid_check_en && ent_aid != 0 && matched) begin
      w = 1'b0;
      if (req_kind == 2'd2) begin perm = {x, w, r}; flt = 4'd3; tag = "R6"; return; end
    end
    perm = {x, w, r};
    if (req_kind == 2'd0) begin tag = "R8"; return; end
    need_ok = (req_kind == 2'd1) ? r : (req_kind == 2'd2) ? w : x;
    if (!need_ok) begin
      tag = "R9";
      flt = (req_kind == 2'd3) ? 4'd4 : (r ? 4'd5 : 4'd6);
      return;
    end
    if (ent_ref_trap) perm = {x, 2'b00};
    else if (!ent_dirty || ent_brk) perm = {x, 1'b0, r};
    if (ent_ref_trap && req_kind != 2'd3) begin flt = 4'd9; tag = "R12"; end
    else if (ent_brk && req_kind == 2'd2) begin flt = 4'd8; tag = "R11"; end
    else if (!ent_dirty && req_kind == 2'd2) begin flt = 4'd7; tag = "R10"; end
    else tag = "R5";
  endtask

  task automatic run_one(input string force_tag);
    logic [PA_W-1:0] epa; logic [2:0] eperm; logic [3:0] eflt; string tag;
    model(epa, eperm, eflt, tag);
    if (force_tag != "") tag = force_tag;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R13", "valid", 64'(out_valid), 64'd1);
    check(tag == "R1" ? "R1" : (tag == "R2" ? "R2" : "R3"), "pa", 64'(out_pa), 64'(epa));
    check(tag, "perm", 64'(out_perm), 64'(eperm));
    check(tag, "fault", 64'(out_fault), 64'(eflt));
  endtask

  task automatic set_entry(input logic [1:0] ring, input logic [1:0] kind,
                           input logic [1:0] pl_rd, input logic [1:0] pl_wr,
                           input logic [2:0] typ, input bit d, input bit b, input bit t);
    req_phys_mode = 1'b0; ent_hit = 1'b1;
    req_ring = ring; req_kind = kind; ent_pl_rd = pl_rd; ent_pl_wr = pl_wr;
    ent_type = typ; ent_dirty = d; ent_brk = b; ent_ref_trap = t;
    ent_aid = '0; pid_check_en = 1'b0; pid_regs = '0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL R13 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R13: reset state
    check("R13", "reset valid", 64'(out_valid), 64'd0);
    check("R13", "reset pa", 64'(out_pa), 64'd0);
    check("R13", "reset perm", 64'(out_perm), 64'd0);
    check("R13", "reset fault", 64'(out_fault), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: physical mode ignores a missing entry
    set_entry(2'd3, 2'd2, 2'd0, 2'd0, 3'd0, 1'b0, 1'b1, 1'b1);
    req_phys_mode = 1'b1; ent_hit = 1'b0; req_va = 32'hDEAD_BEEF;
    run_one("R1");
    // R2: misses
    set_entry(2'd0, 2'd3, 2'd3, 2'd0, 3'd3, 1'b1, 1'b0, 1'b0); ent_hit = 1'b0;
    run_one("R2");
    req_kind = 2'd1; run_one("R2");
    // R3: address composition
    set_entry(2'd0, 2'd1, 2'd3, 2'd3, 3'd1, 1'b1, 1'b0, 1'b0);
    ent_frame = 20'hABCDE; req_va = 32'h1234_5678;
    run_one("R3");
    check("R3", "pa literal", 64'(out_pa), 64'hABCD_E678);
    // R4: ring outside read bound, then execute inside both bounds
    set_entry(2'd2, 2'd1, 2'd1, 2'd0, 3'd3, 1'b1, 1'b0, 1'b0);
    run_one("R4");
    check("R4", "fault rights", 64'(out_fault), 64'd6);
    set_entry(2'd1, 2'd3, 2'd2, 2'd0, 3'd3, 1'b1, 1'b0, 1'b0);
    run_one("R4");
    check("R4", "perm rx", 64'(out_perm), 64'd5);
    // R5: execute-only type, read-only type
    set_entry(2'd0, 2'd1, 2'd3, 2'd0, 3'd5, 1'b1, 1'b0, 1'b0);
    run_one("R5");
    set_entry(2'd0, 2'd2, 2'd3, 2'd3, 3'd0, 1'b1, 1'b0, 1'b0);
    run_one("R5");
    check("R9", "dprot", 64'(out_fault), 64'd5);
    // R6: protection-ID match
    set_entry(2'd0, 2'd2, 2'd3, 2'd3, 3'd1, 1'b1, 1'b0, 1'b0);
    ent_aid = 18'h155; pid_check_en = 1'b1;
    pid_regs[2*PID_W +: PID_W] = 32'(18'h155) * 2 + 1;
    run_one("R6");
    check("R6", "pid fault", 64'(out_fault), 64'd3);
    req_kind = 2'd1; run_one("R6");
    check("R6", "read perm", 64'(out_perm), 64'd1);
    // R7: disabled, and public tag
    req_kind = 2'd2; pid_check_en = 1'b0; run_one("R7");
    check("R7", "write kept", 64'(out_perm), 64'd3);
    pid_check_en = 1'b1; ent_aid = '0;
    pid_regs = {N_PID{32'd1}};
    run_one("R7");
    check("R7", "public fault", 64'(out_fault), 64'd0);
    // R8: probe skips status
    set_entry(2'd3, 2'd0, 2'd3, 2'd0, 3'd4, 1'b0, 1'b1, 1'b1);
    run_one("R8");
    check("R8", "probe perm", 64'(out_perm), 64'd4);
    // R10, R11, R12
    set_entry(2'd0, 2'd2, 2'd3, 2'd3, 3'd1, 1'b0, 1'b0, 1'b0);
    run_one("R10");
    check("R10", "dirty", 64'(out_fault), 64'd7);
    ent_brk = 1'b1; run_one("R11");
    check("R11", "break", 64'(out_fault), 64'd8);
    set_entry(2'd0, 2'd2, 2'd3, 2'd0, 3'd3, 1'b0, 1'b1, 1'b1);
    run_one("R12");
    check("R12", "pageref perm", 64'(out_perm), 64'd4);
    req_kind = 2'd3; ent_dirty = 1'b1; ent_brk = 1'b0; run_one("R12");
    check("R12", "exec no fault", 64'(out_fault), 64'd0);
    // R13: idle cycle drops valid and holds results
    @(negedge clk);
    check("R13", "idle valid", 64'(out_valid), 64'd0);
    check("R13", "idle perm held", 64'(out_perm), 64'd4);

    for (int n = 0; n < 3000; n++) begin
      int sel;
      req_va = $urandom; ent_frame = FR_W'($urandom);
      req_ring = 2'($urandom); req_kind = 2'($urandom);
      ent_pl_rd = 2'($urandom); ent_pl_wr = 2'($urandom); ent_type = 3'($urandom);
      ent_dirty = 1'($urandom); ent_brk = 1'($urandom_range(0, 3) == 0);
      ent_ref_trap = 1'($urandom_range(0, 3) == 0);
      sel = $urandom_range(0, 9);
      req_phys_mode = (sel == 0); ent_hit = (sel != 1);
      ent_aid = ($urandom_range(0, 3) == 0) ? '0 : AID_W'($urandom);
      pid_check_en = 1'($urandom);
      for (int k = 0; k < N_PID; k++) pid_regs[k*PID_W +: PID_W] = $urandom;
      if ($urandom_range(0, 2) == 0)
        pid_regs[$urandom_range(0, N_PID-1)*PID_W +: PID_W] = PID_W'({ent_aid, 1'b1});
      run_one("");
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule